// File: doc/BRIEF.md
# Nested Preemptive Priority Interrupt Controller

This block takes up to sixteen maskable request lines and one non-maskable line. It decides which request the processor should take next and when that request may interrupt the code that is running. Each maskable source has a programmable urgency value, an enable flag, a latched pending flag and an active flag. A smaller urgency value means a more urgent source. The controller finds the most urgent pending source that is enabled. It raises a registered take strobe carrying the vector number of that source, but only when the source is strictly more urgent than the current execution level.

The processor answers a take with an acknowledge pulse. It closes each handler with an end-of-handler pulse that carries the vector number. The controller records the nesting of handlers through these two pulses. The execution level is always recomputed from every handler that is still active, using each handler's programmed urgency. Lowering the urgency of a running handler therefore cannot let a handler it preempted run ahead of it. A small write port configures the sources, and a read port returns one source's urgency. The pending and active vectors are visible at all times.

Top module: `irqc_top`

## Requirements
- R1: After reset there is no take, the execution level reads 0x100 (thread level), nesting depth and maximum depth are 0, nothing is pending, enabled or active, and every source's urgency reads back as 0x80.
- R2: Among the sources that are pending and enabled, the one with the smallest urgency value is chosen; on a tie the lowest source number wins. The take output shows it on the edge that latches the request.
- R3: A maskable take is raised only when the chosen urgency is numerically smaller than the execution level. An equal or larger value stays pending.
- R4: An acknowledge while take is valid clears that source's pending bit and sets its active bit. On the same edge the execution level becomes the most urgent value among the active handlers.
- R5: An end-of-handler pulse for vector v clears active bit v. A request or handover in that same cycle is judged against the lowered execution level, so its take appears on that same edge.
- R6: The execution level is the minimum urgency over all active handlers, or 0x100 when none is active. Rewriting a running handler's urgency to a larger value drops the level only as far as the most urgent other active handler.
- R7: Each source holds a single pending bit. Repeated requests while it is pending merge into one, and one acknowledge consumes them all.
- R8: The non-maskable source (vector number 16) is taken ahead of any maskable source and regardless of any enable. While its handler is active, no maskable source is taken.
- R9: While the global enable is low, no maskable take is raised, but requests still set pending bits. Raising the enable lets the waiting source be taken.
- R10: The write port sets or clears a source's pending bit (operation 2 sets, 3 clears), writes its urgency (operation 0) or its enable from data bit 0 (operation 1). A software-set pending bit is taken like a hardware request.
- R11: A pending source whose enable is clear is never taken, and its pending bit stays set.
- R12: The depth output counts the active handlers, including the non-maskable one. The maximum-depth output holds the largest depth seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 16 | Maskable request lines, sampled each cycle |
| nmi_req | input | 1 | Non-maskable request line |
| glob_en | input | 1 | Global maskable enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 urgency, 1 enable, 2 set pending, 3 clear pending |
| cfg_id | input | 5 | Source addressed by write and read |
| cfg_wdata | input | 8 | Write data |
| rd_prio | output | 8 | Urgency of source cfg_id |
| ack | input | 1 | Processor takes the offered vector |
| eoh | input | 1 | End-of-handler strobe |
| eoh_id | input | 5 | Vector whose handler ends |
| take_v | output | 1 | Take request to the processor |
| take_id | output | 5 | Vector offered, 16 for non-maskable |
| exec_prio | output | 9 | Current execution level |
| pend_o | output | 16 | Pending bits |
| en_o | output | 16 | Enable bits |
| act_o | output | 16 | Active bits |
| nmi_pend_o | output | 1 | Non-maskable pending |
| nmi_act_o | output | 1 | Non-maskable handler active |
| depth_o | output | 5 | Current nesting depth |
| max_depth_o | output | 5 | Largest nesting depth seen |

## Verification
The arbiter is tried with two equal-urgency sources raised together, which separates the source-number tie-break from a plain urgency compare. It is also tried with a more urgent source arriving over a running handler, which separates strict preemption from equal-level blocking. The urgency of a nested handler is rewritten while it is running, which distinguishes a level recomputed from all active handlers from one that only follows the newest handler. Repeated pulses under a cleared global enable, a disabled source, software set and clear, and non-maskable requests that collide with maskable ones show that pending bits merge, survive masking and yield to the non-maskable path. A behavioural model checks every output on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        CFG_PRIO = 2'd0,
        CFG_EN   = 2'd1,
        CFG_SETP = 2'd2,
        CFG_CLRP = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 8,
    parameter int ID_W   = 5
) (
    input  logic [N_SRC-1:0]             cand,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output logic                         found,
    output logic [ID_W-1:0]              best_id,
    output logic [PRIO_W-1:0]            best_prio
);
    // Ascending scan with strict compare: the lowest number wins a tie.
    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && (!found || (prio[i] < best_prio))) begin
                found     = 1'b1;
                best_id   = ID_W'(i);
                best_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irqc_exec_lvl.sv
module irqc_exec_lvl #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 8
) (
    input  logic [N_SRC-1:0]             act,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output logic [PRIO_W:0]              lvl
);
    localparam logic [PRIO_W:0] THREAD_LVL = {1'b1, {PRIO_W{1'b0}}};

    always_comb begin
        lvl = THREAD_LVL;
        for (int i = 0; i < N_SRC; i++) begin
            if (act[i] && ({1'b0, prio[i]} < lvl)) begin
                lvl = {1'b0, prio[i]};
            end
        end
    end
endmodule

// File: rtl/irqc_depth.sv
module irqc_depth #(
    parameter int N_SRC   = 16,
    parameter int DEPTH_W = 5
) (
    input  logic [N_SRC-1:0]   act,
    input  logic               nmi_act,
    output logic [DEPTH_W-1:0] cnt
);
    always_comb begin
        cnt = DEPTH_W'(nmi_act);
        for (int i = 0; i < N_SRC; i++) begin
            cnt = cnt + DEPTH_W'(act[i]);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 8,
    localparam int ID_W  = $clog2(N_SRC + 1),
    localparam int DEPTH_W = $clog2(N_SRC + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   irq_req,
    input  logic               nmi_req,
    input  logic               glob_en,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_op,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic [PRIO_W-1:0]  cfg_wdata,
    output logic [PRIO_W-1:0]  rd_prio,
    input  logic               ack,
    input  logic               eoh,
    input  logic [ID_W-1:0]    eoh_id,
    output logic               take_v,
    output logic [ID_W-1:0]    take_id,
    output logic [PRIO_W:0]    exec_prio,
    output logic [N_SRC-1:0]   pend_o,
    output logic [N_SRC-1:0]   en_o,
    output logic [N_SRC-1:0]   act_o,
    output logic               nmi_pend_o,
    output logic               nmi_act_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic [DEPTH_W-1:0] max_depth_o
);
    import irqc_pkg::*;

    localparam logic [ID_W-1:0]   NMI_ID     = ID_W'(N_SRC);
    localparam logic [PRIO_W-1:0] PRIO_MID   = PRIO_W'(1) << (PRIO_W - 1);
    localparam logic [PRIO_W:0]   THREAD_LVL = {1'b1, {PRIO_W{1'b0}}};
    localparam logic [N_SRC-1:0][PRIO_W-1:0] PRIO_INIT = {N_SRC{PRIO_MID}};

    typedef struct packed {
        logic [N_SRC-1:0]             pend;
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0]             act;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
        logic                         nmi_pend;
        logic                         nmi_act;
    } core_t;

    typedef struct packed {
        logic               take_v;
        logic [ID_W-1:0]    take_id;
        logic [PRIO_W:0]    exec;
        logic [DEPTH_W-1:0] depth;
        logic [DEPTH_W-1:0] maxd;
    } out_t;

    core_t core_d, core_q;
    out_t  out_d, out_q;

    cfg_op_e op;
    logic    ack_hit;
    logic    nmi_ack, nmi_eoh;
    logic [N_SRC-1:0] sel_v, ack_v, eoh_v;

    assign op      = cfg_op_e'(cfg_op);
    assign ack_hit = ack & out_q.take_v;
    assign nmi_ack = ack_hit && (out_q.take_id == NMI_ID);
    assign nmi_eoh = eoh && (eoh_id == NMI_ID);

    // Per-source decode of the three strobes.
    for (genvar g = 0; g < N_SRC; g++) begin : g_dec
        assign sel_v[g] = cfg_we  && (cfg_id == ID_W'(g));
        assign ack_v[g] = ack_hit && (out_q.take_id == ID_W'(g));
        assign eoh_v[g] = eoh     && (eoh_id == ID_W'(g));
    end

    // Next source state.
    always_comb begin
        core_d = core_q;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_v[i] && (op == CFG_PRIO)) core_d.prio[i] = cfg_wdata;
            if (sel_v[i] && (op == CFG_EN))   core_d.en[i]   = cfg_wdata[0];
            core_d.pend[i] = (core_q.pend[i]
                              & ~(sel_v[i] && (op == CFG_CLRP))
                              & ~ack_v[i])
                             | irq_req[i]
                             | (sel_v[i] && (op == CFG_SETP));
            core_d.act[i]  = (core_q.act[i] | ack_v[i]) & ~eoh_v[i];
        end
        core_d.nmi_pend = (core_q.nmi_pend & ~nmi_ack) | nmi_req;
        core_d.nmi_act  = (core_q.nmi_act | nmi_ack) & ~nmi_eoh;
    end

    logic                found;
    logic [ID_W-1:0]     best_id;
    logic [PRIO_W-1:0]   best_prio;
    logic [PRIO_W:0]     lvl;
    logic [DEPTH_W-1:0]  cnt;

    irqc_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .cand      (core_d.pend & core_d.en),
        .prio      (core_d.prio),
        .found     (found),
        .best_id   (best_id),
        .best_prio (best_prio)
    );

    irqc_exec_lvl #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_lvl (
        .act  (core_d.act),
        .prio (core_d.prio),
        .lvl  (lvl)
    );

    irqc_depth #(.N_SRC(N_SRC), .DEPTH_W(DEPTH_W)) u_depth (
        .act     (core_d.act),
        .nmi_act (core_d.nmi_act),
        .cnt     (cnt)
    );

    // Next offer, level and nesting counters, judged on updated state.
    always_comb begin
        out_d         = out_q;
        out_d.exec    = lvl;
        out_d.depth   = cnt;
        out_d.maxd    = (cnt > out_q.maxd) ? cnt : out_q.maxd;
        out_d.take_v  = 1'b0;
        out_d.take_id = '0;
        if (core_d.nmi_pend && !core_d.nmi_act) begin
            out_d.take_v  = 1'b1;
            out_d.take_id = NMI_ID;
        end else if (glob_en && !core_d.nmi_act && found &&
                     ({1'b0, best_prio} < lvl)) begin
            out_d.take_v  = 1'b1;
            out_d.take_id = best_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{pend: '0, en: '0, act: '0, prio: PRIO_INIT,
                        nmi_pend: 1'b0, nmi_act: 1'b0};
            out_q  <= '{take_v: 1'b0, take_id: '0, exec: THREAD_LVL,
                        depth: '0, maxd: '0};
        end else begin
            core_q <= core_d;
            out_q  <= out_d;
        end
    end

    always_comb begin
        rd_prio = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cfg_id == ID_W'(i)) rd_prio = core_q.prio[i];
        end
    end

    assign take_v      = out_q.take_v;
    assign take_id     = out_q.take_id;
    assign exec_prio   = out_q.exec;
    assign pend_o      = core_q.pend;
    assign en_o        = core_q.en;
    assign act_o       = core_q.act;
    assign nmi_pend_o  = core_q.nmi_pend;
    assign nmi_act_o   = core_q.nmi_act;
    assign depth_o     = out_q.depth;
    assign max_depth_o = out_q.maxd;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 8,
    parameter int ID_W   = 5,
    parameter int DEPTH_W = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         glob_en,
    input logic                         ack,
    input logic                         eoh,
    input logic [ID_W-1:0]              eoh_id,
    input logic                         take_v,
    input logic [ID_W-1:0]              take_id,
    input logic [PRIO_W:0]              exec_prio,
    input logic [N_SRC-1:0]             pend,
    input logic [N_SRC-1:0]             en,
    input logic [N_SRC-1:0]             act,
    input logic [N_SRC-1:0][PRIO_W-1:0] prio,
    input logic                         nmi_pend,
    input logic                         nmi_act,
    input logic [DEPTH_W-1:0]           depth,
    input logic [DEPTH_W-1:0]           maxd
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [ID_W-1:0] NMI_ID = ID_W'(N_SRC);
    localparam logic [PRIO_W:0] THREAD_LVL = {1'b1, {PRIO_W{1'b0}}};

    // R2: a maskable offer is always a pending, enabled source
    assert_offer_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_v && take_id != NMI_ID) |-> (pend[take_id[IW-1:0]] && en[take_id[IW-1:0]]));

    // R3: a maskable offer is strictly more urgent than the execution level
    assert_strict_preempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_v && take_id != NMI_ID) |-> ({1'b0, prio[take_id[IW-1:0]]} < exec_prio));

    // R4: acknowledge of a maskable offer marks it active
    assert_ack_activates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && take_v && take_id != NMI_ID && !eoh) |=> act[$past(take_id[IW-1:0])]);

    // R5: end-of-handler clears the named active bit
    assert_eoh_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoh && eoh_id != NMI_ID) |=> !act[$past(eoh_id[IW-1:0])]);

    // R6: no active handler means thread level
    assert_thread_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (exec_prio == THREAD_LVL));

    // R8: a waiting non-maskable request is offered ahead of everything
    assert_nmi_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !nmi_act) |-> (take_v && take_id == NMI_ID));

    // R9: with the global enable low only the non-maskable vector is offered
    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!glob_en) && take_v) |-> (take_id == NMI_ID));

    // R12: the maximum never trails the current depth
    assert_max_depth_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (maxd >= depth) && (int'(depth) == $countones(act) + int'(nmi_act)));
endmodule

bind irqc_top irqc_chk #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .DEPTH_W(DEPTH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_en   (glob_en),
    .ack       (ack),
    .eoh       (eoh),
    .eoh_id    (eoh_id),
    .take_v    (take_v),
    .take_id   (take_id),
    .exec_prio (exec_prio),
    .pend      (pend_o),
    .en        (en_o),
    .act       (act_o),
    .prio      (core_q.prio),
    .nmi_pend  (nmi_pend_o),
    .nmi_act   (nmi_act_o),
    .depth     (depth_o),
    .maxd      (max_depth_o)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
    localparam int N = 16;
    localparam int NMI = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic        nmi_req = 1'b0;
    logic        glob_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_op = '0;
    logic [4:0]  cfg_id = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        ack = 1'b0;
    logic        eoh = 1'b0;
    logic [4:0]  eoh_id = '0;
    logic [7:0]  rd_prio;
    logic        take_v;
    logic [4:0]  take_id;
    logic [8:0]  exec_prio;
    logic [15:0] pend_o, en_o, act_o;
    logic        nmi_pend_o, nmi_act_o;
    logic [4:0]  depth_o, max_depth_o;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .glob_en(glob_en), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_id(cfg_id),
        .cfg_wdata(cfg_wdata), .rd_prio(rd_prio), .ack(ack), .eoh(eoh),
        .eoh_id(eoh_id), .take_v(take_v), .take_id(take_id),
        .exec_prio(exec_prio), .pend_o(pend_o), .en_o(en_o), .act_o(act_o),
        .nmi_pend_o(nmi_pend_o), .nmi_act_o(nmi_act_o), .depth_o(depth_o),
        .max_depth_o(max_depth_o)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_prio[N];
    bit m_en[N], m_pend[N], m_act[N];
    bit m_npend, m_nact, m_tv;
    int m_tid, m_exec, m_depth, m_max;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 128; m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0;
            end
            m_npend = 0; m_nact = 0; m_tv = 0; m_tid = 0;
            m_exec = 256; m_depth = 0; m_max = 0;
        end else begin
            bit took;
            int tid, best, bid;
            took = ack && m_tv;
            tid  = m_tid;
            for (int i = 0; i < N; i++) begin
                bit hit;
                hit = cfg_we && (int'(cfg_id) == i);
                if (hit && cfg_op == 2'd0) m_prio[i] = int'(cfg_wdata);
                if (hit && cfg_op == 2'd1) m_en[i] = cfg_wdata[0];
                if (hit && cfg_op == 2'd3) m_pend[i] = 0;
                if (took && tid == i) begin m_pend[i] = 0; m_act[i] = 1; end
                if (irq_req[i] || (hit && cfg_op == 2'd2)) m_pend[i] = 1;
                if (eoh && int'(eoh_id) == i) m_act[i] = 0;
            end
            if (took && tid == NMI) begin m_npend = 0; m_nact = 1; end
            if (nmi_req) m_npend = 1;
            if (eoh && int'(eoh_id) == NMI) m_nact = 0;
            m_exec = 256; m_depth = m_nact;
            for (int i = 0; i < N; i++) if (m_act[i]) begin
                m_depth++;
                if (m_prio[i] < m_exec) m_exec = m_prio[i];
            end
            if (m_depth > m_max) m_max = m_depth;
            best = 1000; bid = -1;
            for (int i = 0; i < N; i++)
                if (m_pend[i] && m_en[i] && m_prio[i] < best) begin best = m_prio[i]; bid = i; end
            m_tv = 0; m_tid = 0;
            if (m_npend && !m_nact) begin m_tv = 1; m_tid = NMI; end
            else if (glob_en && !m_nact && bid >= 0 && best < m_exec) begin m_tv = 1; m_tid = bid; end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] ep, ea;
            for (int i = 0; i < N; i++) begin ep[i] = m_pend[i]; ea[i] = m_act[i]; end
            chk("R2", "model take_v", int'(take_v), int'(m_tv));
            if (m_tv) chk("R2", "model take_id", int'(take_id), m_tid);
            chk("R6", "model exec", int'(exec_prio), m_exec);
            chk("R7", "model pend", int'(pend_o), int'(ep));
            chk("R4", "model act", int'(act_o), int'(ea));
            chk("R8", "model nmi_act", int'(nmi_act_o), int'(m_nact));
            chk("R12", "model depth", int'(depth_o), m_depth);
            chk("R12", "model maxd", int'(max_depth_o), m_max);
        end
    end

    task automatic wr(input int op, input int id, input int data);
        cfg_we = 1; cfg_op = 2'(op); cfg_id = 5'(id); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask
    task automatic req(input logic [15:0] m);
        irq_req = m; @(negedge clk); irq_req = '0;
    endtask
    task automatic do_ack;
        ack = 1; @(negedge clk); ack = 0;
    endtask
    task automatic end_h(input int id);
        eoh = 1; eoh_id = 5'(id); @(negedge clk); eoh = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cfg_id = 5'd3; #1;
        // R1 reset state
        chk("R1", "take_v", int'(take_v), 0);
        chk("R1", "exec", int'(exec_prio), 256);
        chk("R1", "depth", int'(depth_o), 0);
        chk("R1", "max", int'(max_depth_o), 0);
        chk("R1", "pend", int'(pend_o), 0);
        chk("R1", "rd_prio", int'(rd_prio), 128);
        @(negedge clk);
        glob_en = 1;
        wr(0, 3, 8'h40); wr(0, 5, 8'h40); wr(0, 7, 8'h20);
        wr(0, 2, 8'h60); wr(0, 9, 8'h10);
        wr(1, 2, 1); wr(1, 3, 1); wr(1, 5, 1); wr(1, 7, 1); wr(1, 9, 1);
        cfg_id = 5'd7; #1;
        chk("R10", "rd_prio src7", int'(rd_prio), 8'h20);
        chk("R10", "en bits", int'(en_o), 16'h02AC);
        @(negedge clk);
        // R2 tie between 3 and 5
        req(16'h0028);
        chk("R2", "tie take_v", int'(take_v), 1);
        chk("R2", "tie take_id", int'(take_id), 3);
        do_ack;
        chk("R4", "exec after ack", int'(exec_prio), 8'h40);
        chk("R4", "act3", int'(act_o[3]), 1);
        chk("R4", "pend3 cleared", int'(pend_o[3]), 0);
        chk("R3", "equal level no take", int'(take_v), 0);
        chk("R3", "equal stays pending", int'(pend_o[5]), 1);
        req(16'h0080);
        chk("R3", "preempt take_id", int'(take_id), 7);
        do_ack;
        chk("R4", "nested exec", int'(exec_prio), 8'h20);
        chk("R12", "depth 2", int'(depth_o), 2);
        // R6 demote running handler
        wr(0, 7, 8'hF0);
        chk("R6", "demoted exec", int'(exec_prio), 8'h40);
        chk("R6", "no inversion take", int'(take_v), 0);
        end_h(7);
        chk("R5", "exec after eoh7", int'(exec_prio), 8'h40);
        end_h(3);
        chk("R5", "handover take_id", int'(take_id), 5);
        chk("R5", "handover take_v", int'(take_v), 1);
        do_ack;
        // R5 request in same cycle as end-of-handler
        irq_req = 16'h0004; eoh = 1; eoh_id = 5'd5;
        @(negedge clk);
        irq_req = '0; eoh = 0;
        chk("R5", "same-cycle take_id", int'(take_id), 2);
        chk("R5", "same-cycle exec", int'(exec_prio), 256);
        do_ack; end_h(2);
        // R9 and R7
        glob_en = 0;
        req(16'h0200); @(negedge clk); req(16'h0200); req(16'h0200);
        chk("R9", "masked pend", int'(pend_o[9]), 1);
        chk("R9", "masked no take", int'(take_v), 0);
        glob_en = 1; @(negedge clk);
        chk("R9", "unmasked take_id", int'(take_id), 9);
        do_ack; end_h(9);
        chk("R7", "merged single service", int'(pend_o[9]), 0);
        chk("R7", "no second take", int'(take_v), 0);
        // R11 disabled source, R10 clear
        req(16'h0800);
        chk("R11", "disabled pend", int'(pend_o[11]), 1);
        chk("R11", "disabled no take", int'(take_v), 0);
        wr(3, 11, 0);
        chk("R10", "sw clear", int'(pend_o[11]), 0);
        wr(2, 3, 0);
        chk("R10", "sw set take_id", int'(take_id), 3);
        do_ack; end_h(3);
        // R8 non-maskable
        glob_en = 0;
        nmi_req = 1; @(negedge clk); nmi_req = 0;
        chk("R8", "nmi under mask", int'(take_id), NMI);
        do_ack;
        chk("R8", "nmi active", int'(nmi_act_o), 1);
        glob_en = 1;
        req(16'h0200);
        chk("R8", "maskable held off", int'(take_v), 0);
        end_h(NMI);
        chk("R8", "after nmi take_id", int'(take_id), 9);
        do_ack; end_h(9);
        irq_req = 16'h0200; nmi_req = 1; @(negedge clk);
        irq_req = '0; nmi_req = 0;
        chk("R8", "nmi beats src9", int'(take_id), NMI);
        do_ack; end_h(NMI);
        chk("R8", "src9 after nmi", int'(take_id), 9);
        do_ack; end_h(9);
        chk("R12", "final max depth", int'(max_depth_o), 2);
        chk("R12", "final depth", int'(depth_o), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule